// File: doc/BRIEF.md
# Synthesizer Lock Detector and Power Control

This block decides whether the frequency synthesizer is powered and reports when its loop is in phase lock. The powered state comes from two control inputs, an enable bit and a chip-mode enable: with the enable bit set, power follows the chip mode, and with it clear, power is the opposite of the chip mode. Each time power returns, the block emits a one-cycle strobe that restarts the main and reference dividers together, so they wake up in phase.

Lock is judged digitally on the crystal clock. The block watches the reference-divider and main-divider output pulses and measures the gap between matching rising edges in whole crystal periods. Two edges on the same sample, or on adjacent samples, count as in window. A longer gap, or an edge with no partner, counts as out of window. The lock output rises after a run of four in-window comparisons in a row. It falls at the first out-of-window comparison, and it is held low whenever the synthesizer is powered down.

Top module: `synth_lock_ctrl`

## Requirements
- R1: While en_bit is 1, synth_pwr takes the value of mode_en as registered at the previous clock edge.
- R2: While en_bit is 0, synth_pwr takes the inverse of mode_en as registered at the previous clock edge.
- R3: div_sync is high for exactly one cycle, and that cycle is the first one in which synth_pwr is 1 after having been 0.
- R4: lock is 0 in every cycle in which synth_pwr is 0.
- R5: A rising edge on ref_div and a rising edge on main_div seen on the same clock sample, or on adjacent samples in either order, form one in-window comparison.
- R6: If one divider edge is followed by no edge from the other divider within 2 clock samples (a gap of 2 or more, or no partner at all), the comparison is out of window.
- R7: lock rises only after 4 consecutive in-window comparisons. It is high within 2 cycles of the sample that completes the fourth one.
- R8: lock falls to 0 within 3 cycles of the first edge of an out-of-window comparison.
- R9: The run of in-window comparisons is cleared whenever power is off, so after power returns 4 new in-window comparisons are needed before lock rises.
- R10: In the cycle after synchronous reset, synth_pwr, div_sync and lock are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal clock; it sets the lock window |
| rst | input | 1 | Synchronous active-high reset |
| ref_div | input | 1 | Reference-divider output pulse |
| main_div | input | 1 | Main-divider output pulse |
| en_bit | input | 1 | Power polarity bit: 1 follows mode_en, 0 inverts it |
| mode_en | input | 1 | Chip-mode enable for the synthesizer section |
| lock | output | 1 | Phase lock indication, high when locked |
| synth_pwr | output | 1 | Synthesizer power enable |
| div_sync | output | 1 | One-cycle divider resynchronization strobe |

## Verification
The assertions assume that ref_div and main_div are already synchronous to clk. They also assume that en_bit and mode_en change only between edges, so one registered sample decides the power state. The stimulus drives every input on the falling edge and raises each divider pulse for a single cycle. Between comparisons it leaves several idle cycles, so that each pair of edges is judged alone and the run counter sees one clean result per pair.

// File: rtl/synth_lock_pkg.sv
package synth_lock_pkg;

    // Edges this many samples apart still count as in window.
    localparam int unsigned DEF_SLACK   = 1;
    // A lone edge becomes out of window after this many samples.
    localparam int unsigned DEF_TIMEOUT = 2;
    // In-window comparisons in a row needed to declare lock.
    localparam int unsigned DEF_RUN     = 4;

    typedef enum logic [1:0] {
        CMP_IDLE      = 2'd0,
        CMP_WAIT_MAIN = 2'd1,
        CMP_WAIT_REF  = 2'd2
    } cmp_state_e;

    typedef struct packed {
        logic valid;
        logic in_win;
    } cmp_result_t;

    function automatic logic pwr_map(input logic en, input logic mode);
        return en ? mode : ~mode;
    endfunction

endpackage

// File: rtl/slc_pwr_ctrl.sv
module slc_pwr_ctrl
    import synth_lock_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic en_bit,
    input  logic mode_en,
    output logic pwr_q,
    output logic sync_q
);
    logic pwr_next;

    assign pwr_next = pwr_map(en_bit, mode_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            pwr_q  <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            pwr_q  <= pwr_next;
            sync_q <= pwr_next & ~pwr_q;
        end
    end
endmodule

// File: rtl/slc_edge_cmp.sv
module slc_edge_cmp
    import synth_lock_pkg::*;
#(
    parameter int unsigned SLACK   = DEF_SLACK,
    parameter int unsigned TIMEOUT = DEF_TIMEOUT
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        enable,
    input  logic        ref_div,
    input  logic        main_div,
    output cmp_result_t result
);
    localparam int unsigned CW = $clog2(TIMEOUT + 1);
    localparam logic [CW-1:0] SLACK_C = CW'(SLACK);
    localparam logic [CW-1:0] TOUT_C  = CW'(TIMEOUT);

    cmp_state_e    state;
    logic [CW-1:0] gap_cnt;
    logic          ref_d, main_d;
    logic          ref_e, main_e, other_e;

    assign ref_e   = ref_div & ~ref_d;
    assign main_e  = main_div & ~main_d;
    assign other_e = (state == CMP_WAIT_MAIN) ? main_e : ref_e;

    always_ff @(posedge clk) begin
        if (rst) begin
            ref_d  <= 1'b0;
            main_d <= 1'b0;
        end else begin
            ref_d  <= ref_div;
            main_d <= main_div;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            state   <= CMP_IDLE;
            gap_cnt <= '0;
            result  <= '0;
        end else begin
            result <= '0;
            case (state)
                CMP_IDLE: begin
                    if (ref_e && main_e) begin
                        result <= '{valid: 1'b1, in_win: 1'b1};
                    end else if (ref_e) begin
                        state   <= CMP_WAIT_MAIN;
                        gap_cnt <= CW'(1);
                    end else if (main_e) begin
                        state   <= CMP_WAIT_REF;
                        gap_cnt <= CW'(1);
                    end
                end
                default: begin
                    if (other_e && gap_cnt <= SLACK_C) begin
                        result <= '{valid: 1'b1, in_win: 1'b1};
                        state  <= CMP_IDLE;
                    end else if (other_e || gap_cnt >= TOUT_C) begin
                        result <= '{valid: 1'b1, in_win: 1'b0};
                        state  <= CMP_IDLE;
                    end else begin
                        gap_cnt <= gap_cnt + CW'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/slc_lock_filter.sv
module slc_lock_filter
    import synth_lock_pkg::*;
#(
    parameter int unsigned RUN = DEF_RUN
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pwr,
    input  cmp_result_t result,
    output logic        lock_q
);
    localparam int unsigned RW = $clog2(RUN + 1);
    localparam logic [RW-1:0] LAST_C = RW'(RUN - 1);
    localparam logic [RW-1:0] FULL_C = RW'(RUN);

    logic [RW-1:0] run_cnt;

    always_ff @(posedge clk) begin
        if (rst || !pwr) begin
            run_cnt <= '0;
            lock_q  <= 1'b0;
        end else if (result.valid) begin
            if (!result.in_win) begin
                run_cnt <= '0;
                lock_q  <= 1'b0;
            end else if (run_cnt >= LAST_C) begin
                run_cnt <= FULL_C;
                lock_q  <= 1'b1;
            end else begin
                run_cnt <= run_cnt + RW'(1);
            end
        end
    end
endmodule

// File: rtl/synth_lock_ctrl.sv
module synth_lock_ctrl
    import synth_lock_pkg::*;
#(
    parameter int unsigned SLACK   = DEF_SLACK,
    parameter int unsigned TIMEOUT = DEF_TIMEOUT,
    parameter int unsigned RUN     = DEF_RUN
) (
    input  logic clk,
    input  logic rst,
    input  logic ref_div,
    input  logic main_div,
    input  logic en_bit,
    input  logic mode_en,
    output logic lock,
    output logic synth_pwr,
    output logic div_sync
);
    logic        pwr_q;
    logic        lock_q;
    cmp_result_t cmp_res;

    slc_pwr_ctrl i_pwr (
        .clk     (clk),
        .rst     (rst),
        .en_bit  (en_bit),
        .mode_en (mode_en),
        .pwr_q   (pwr_q),
        .sync_q  (div_sync)
    );

    slc_edge_cmp #(.SLACK(SLACK), .TIMEOUT(TIMEOUT)) i_cmp (
        .clk      (clk),
        .rst      (rst),
        .enable   (pwr_q),
        .ref_div  (ref_div),
        .main_div (main_div),
        .result   (cmp_res)
    );

    slc_lock_filter #(.RUN(RUN)) i_filt (
        .clk    (clk),
        .rst    (rst),
        .pwr    (pwr_q),
        .result (cmp_res),
        .lock_q (lock_q)
    );

    assign synth_pwr = pwr_q;
    assign lock      = lock_q & pwr_q;
endmodule

// File: rtl/synth_lock_chk.sv
module synth_lock_chk (
    input logic clk,
    input logic rst,
    input logic en_bit,
    input logic mode_en,
    input logic lock,
    input logic synth_pwr,
    input logic div_sync
);
    // R1
    pwr_follow_chk: assert property (@(posedge clk) disable iff (rst)
        en_bit |=> (synth_pwr == $past(mode_en)));

    // R2
    pwr_invert_chk: assert property (@(posedge clk) disable iff (rst)
        !en_bit |=> (synth_pwr == !$past(mode_en)));

    // R3
    sync_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(synth_pwr) |-> div_sync);

    // R3
    sync_only_rise_chk: assert property (@(posedge clk) disable iff (rst)
        div_sync |-> $rose(synth_pwr));

    // R3
    sync_single_chk: assert property (@(posedge clk) disable iff (rst)
        div_sync |=> !div_sync);

    // R4
    lock_off_chk: assert property (@(posedge clk) disable iff (rst)
        !synth_pwr |-> !lock);

    // R9
    lock_not_at_wake_chk: assert property (@(posedge clk) disable iff (rst)
        div_sync |-> !lock);
endmodule

bind synth_lock_ctrl synth_lock_chk i_synth_lock_chk (
    .clk       (clk),
    .rst       (rst),
    .en_bit    (en_bit),
    .mode_en   (mode_en),
    .lock      (lock),
    .synth_pwr (synth_pwr),
    .div_sync  (div_sync)
);

// File: tb/test_synth_lock_ctrl.sv
module test_synth_lock_ctrl;
    localparam time CLK_P = 10ns;

    // Power vectors: {en_bit, mode_en, expected synth_pwr, expected div_sync}
    localparam logic [3:0] PWR_VEC [6] = '{
        4'b1000, 4'b1111, 4'b1110, 4'b0100, 4'b0011, 4'b1000
    };

    logic clk = 1'b0;
    logic rst, ref_div, main_div, en_bit, mode_en;
    logic lock, synth_pwr, div_sync;
    int   n_tests = 0;
    int   n_fail  = 0;
    bit   done    = 1'b0;

    always #(CLK_P / 2) clk = ~clk;

    synth_lock_ctrl i_synth_lock_ctrl (
        .clk       (clk),
        .rst       (rst),
        .ref_div   (ref_div),
        .main_div  (main_div),
        .en_bit    (en_bit),
        .mode_en   (mode_en),
        .lock      (lock),
        .synth_pwr (synth_pwr),
        .div_sync  (div_sync)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // gap < 0: lone edge; gap 0: same sample; otherwise samples apart
    task automatic send_pair(input int gap, input bit ref_first);
        @(negedge clk);
        if (gap == 0) begin
            ref_div = 1'b1; main_div = 1'b1;
        end else if (ref_first) ref_div = 1'b1;
        else main_div = 1'b1;
        @(negedge clk);
        ref_div = 1'b0; main_div = 1'b0;
        if (gap > 0) begin
            repeat (gap - 1) @(negedge clk);
            if (ref_first) main_div = 1'b1;
            else ref_div = 1'b1;
            @(negedge clk);
            ref_div = 1'b0; main_div = 1'b0;
        end
        repeat (6) @(negedge clk);
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ref_div = 1'b0; main_div = 1'b0;
        en_bit = 1'b1; mode_en = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R10 reset state
        check("R10 pwr", synth_pwr, 1'b0);
        check("R10 sync", div_sync, 1'b0);
        check("R10 lock", lock, 1'b0);

        // R1 R2 R3 power vector walk
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            en_bit  = PWR_VEC[i][3];
            mode_en = PWR_VEC[i][2];
            @(negedge clk);
            check(PWR_VEC[i][3] ? "R1 pwr" : "R2 pwr", synth_pwr, PWR_VEC[i][1]);
            check("R3 sync", div_sync, PWR_VEC[i][0]);
        end
        @(negedge clk);
        check("R3 sync one cycle", div_sync, 1'b0);

        // Power on for lock tests
        en_bit = 1'b1; mode_en = 1'b1;
        repeat (3) @(negedge clk);

        // R5 R7: three in-window pairs, no lock yet
        send_pair(0, 1'b1);
        send_pair(1, 1'b1);
        send_pair(0, 1'b1);
        check("R7 no lock after 3", lock, 1'b0);
        send_pair(1, 1'b0);
        check("R5 R7 lock after 4", lock, 1'b1);

        // R6 R8: gap of two samples breaks lock
        send_pair(2, 1'b1);
        check("R6 R8 gap2 drops lock", lock, 1'b0);
        repeat (4) send_pair(1, 1'b0);
        check("R5 relock adjacent", lock, 1'b1);

        // R6 lone edge
        send_pair(-1, 1'b1);
        check("R6 lone edge drops lock", lock, 1'b0);
        repeat (3) send_pair(0, 1'b0);
        send_pair(2, 1'b0);
        send_pair(0, 1'b1);
        check("R8 run restarted", lock, 1'b0);
        repeat (3) send_pair(0, 1'b1);
        check("R7 lock after fresh run", lock, 1'b1);

        // R4 power down forces lock low
        @(negedge clk);
        mode_en = 1'b0;
        @(negedge clk);
        check("R4 pwr off", synth_pwr, 1'b0);
        check("R4 lock low", lock, 1'b0);
        repeat (3) @(negedge clk);

        // R9 power returns with a cleared run
        mode_en = 1'b1;
        @(negedge clk);
        check("R3 sync on wake", div_sync, 1'b1);
        check("R9 lock low on wake", lock, 1'b0);
        repeat (3) send_pair(0, 1'b1);
        check("R9 needs full run", lock, 1'b0);
        send_pair(1, 1'b1);
        check("R9 lock after full run", lock, 1'b1);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule